// File: doc/BRIEF.md
# LCD Quarter-Duty Frame Sequencer

This block turns a 50-segment by 4-common display memory image into the timing and selection signals for a 1/4-duty liquid-crystal panel. It divides one reference tick into common phases. It scans the four commons in turn and tracks the drive polarity. For the common being driven, it gives the on/off state of every segment. It also gives a 2-bit level code for every common and every segment pin, which the analog driver stage decodes into one of the bias voltages. The analog voltage generation, the output buffers and the oscillator are outside this block.

A host drives the configuration inputs: display enable, inhibit, waveform type, bias, frame-rate code, blink code and the two all-pixel overrides. The display memory image is presented as a flat vector. Segment address `k` occupies bits `4k+3..4k`, and bit `n` of that nibble is shown while common `n` is active. Blanking, the all-pixel overrides and blinking act on the segment state with a fixed priority. The phase timing keeps running while the panel is blanked.

Top module: `lcdseq_top`

## Requirements
- R1: Commons are scanned in the cyclic order 0,1,2,3. `com_sel` advances by one after a fixed number of `tick` pulses, chosen by `rate_sel`: code 0 → 8, code 1 → 9, code 2 → 10, code 3 → 12 ticks per common phase. These are the defaults, scaled for 80/71/64/53 frames per second.
- R2: When nothing overrides it, `seg_on[k]` equals `ram_bits[4*k + com_sel]` and follows the memory image combinationally.
- R3: `frame_pulse` is high for exactly one cycle, the cycle after `com_sel` wraps from 3 to 0.
- R4: With `frame_inv`=1, `inv_phase` toggles only when a frame wraps. With `frame_inv`=0, it toggles at every common phase advance.
- R5: While `disp_on`=0 or `inh_n`=0, `seg_on` is all zero and every level code is 00. The phase and blink timing keep running.
- R6: `all_off`=1 forces `seg_on` to all zero, even when `all_on`=1. `all_on`=1 alone forces `seg_on` to all ones, even during the dark half of a blink.
- R7: `blink_sel` 0 disables blinking. Codes 3, 2 and 1 select blink periods of 2, 4 and 8 blink steps of 640 ticks each (2 Hz, 1 Hz and 0.5 Hz). Each period starts with a visible half and ends with a dark half in which `seg_on` is zero. At rate code 0, one blink period spans 40, 80 or 160 frames.
- R8: Level codes for 1/3 bias (`half_bias`=0) with `inv_phase`=0: the active common is 11, idle commons 01, lit segments 00 and unlit segments 10. With `inv_phase`=1: the active common is 00, idle commons 10, lit segments 11 and unlit segments 01.
- R9: With 1/2 bias (`half_bias`=1), idle commons and unlit segments use 01 in both polarities. The active common and lit segments follow R8.
- R10: During reset, `com_sel`=0, `inv_phase`=0 and `frame_pulse`=0, and both dividers restart from zero.
- R11: In a cycle with `tick` low, neither `com_sel` nor `inv_phase` changes on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference tick, one-cycle pulse |
| disp_on | input | 1 | Display enable |
| inh_n | input | 1 | Inhibit input, low blanks the panel |
| frame_inv | input | 1 | 1 = frame inversion, 0 = line inversion |
| half_bias | input | 1 | 1 = 1/2 bias, 0 = 1/3 bias |
| rate_sel | input | 2 | Frame-rate code |
| blink_sel | input | 2 | Blink-rate code |
| all_on | input | 1 | Force all segments lit |
| all_off | input | 1 | Force all segments dark |
| ram_bits | input | 200 | Display memory image, 4 bits per segment address |
| com_sel | output | 2 | Index of the active common |
| inv_phase | output | 1 | Drive polarity |
| frame_pulse | output | 1 | One-cycle frame boundary marker |
| seg_on | output | 50 | Segment state for the active common |
| com_lvl | output | 8 | 2-bit level code per common |
| seg_lvl | output | 100 | 2-bit level code per segment |

## Verification
A phase divider with a bad count shows up as a `com_sel` step in the wrong cycle, at most one phase (12 ticks) after the fault. A wrong polarity bit flips every level code on the next sample. A blink step counter that is off shows as `seg_on` blanking in the wrong cycle, no later than the next blink half-step of 640 ticks. The bench's behavioural model is compared on every cycle, so each of these faults is reported in the first cycle where it becomes visible at the ports. The frame-per-blink counts catch any drift that adds up slowly.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

   // 2-bit drive level codes handed to the analog stage
   typedef enum logic [1:0] {
      LV_GND = 2'b00,
      LV_LOW = 2'b01,
      LV_UPP = 2'b10,
      LV_TOP = 2'b11
   } lvl_e;

   // level of a common pin: selected or idle, per polarity and bias
   function automatic lvl_e com_level(input logic sel, input logic pol, input logic half);
      if (sel)  return pol ? LV_GND : LV_TOP;
      if (half) return LV_LOW;
      return pol ? LV_UPP : LV_LOW;
   endfunction

   // level of a segment pin: lit or unlit, per polarity and bias
   function automatic lvl_e seg_level(input logic lit, input logic pol, input logic half);
      if (lit)  return pol ? LV_TOP : LV_GND;
      if (half) return LV_LOW;
      return pol ? LV_LOW : LV_UPP;
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/lcdseq_timebase.sv
module lcdseq_timebase #(
   parameter int DIV_R0     = 8,
   parameter int DIV_R1     = 9,
   parameter int DIV_R2     = 10,
   parameter int DIV_R3     = 12,
   parameter int BLINK_HALF = 640
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] rate,
   output logic       ph_adv,
   output logic [2:0] blink_step
);
   localparam int MAXDIV = lcdseq_pkg::max4(DIV_R0, DIV_R1, DIV_R2, DIV_R3);
   localparam int PW     = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;
   localparam int BW     = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;

   if (DIV_R0 < 1 || DIV_R1 < 1 || DIV_R2 < 1 || DIV_R3 < 1) begin : g_bad_div
      $error("lcdseq_timebase: every phase divider must be at least 1");
   end
   if (BLINK_HALF < 1) begin : g_bad_blink
      $error("lcdseq_timebase: BLINK_HALF must be at least 1");
   end

   logic [PW-1:0] ph_cnt;
   logic [PW-1:0] ph_last;
   logic          ph_wrap;
   logic          bk_adv;

   always_comb begin
      case (rate)
         2'd0:    ph_last = PW'(DIV_R0 - 1);
         2'd1:    ph_last = PW'(DIV_R1 - 1);
         2'd2:    ph_last = PW'(DIV_R2 - 1);
         default: ph_last = PW'(DIV_R3 - 1);
      endcase
   end

   // >= so that a switch to a shorter rate mid-phase never overruns
   assign ph_wrap = (ph_cnt >= ph_last);
   assign ph_adv  = tick && ph_wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_cnt <= '0;
      end else if (tick) begin
         ph_cnt <= ph_wrap ? '0 : ph_cnt + 1'b1;
      end
   end

   if (BLINK_HALF == 1) begin : g_bk_direct
      assign bk_adv = tick;
   end else begin : g_bk_prescale
      logic [BW-1:0] bk_cnt;
      logic          bk_wrap;
      assign bk_wrap = (bk_cnt == BW'(BLINK_HALF - 1));
      assign bk_adv  = tick && bk_wrap;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bk_cnt <= '0;
         end else if (tick) begin
            bk_cnt <= bk_wrap ? '0 : bk_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blink_step <= '0;
      end else if (bk_adv) begin
         blink_step <= blink_step + 1'b1;
      end
   end

endmodule

// File: rtl/lcdseq_scan.sv
module lcdseq_scan #(
   parameter  int NCOM = 4,
   localparam int CW   = (NCOM > 1) ? $clog2(NCOM) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ph_adv,
   input  logic          frame_inv,
   output logic [CW-1:0] com_idx,
   output logic          pol,
   output logic          frame_pulse
);
   logic          last_com;
   logic [CW-1:0] com_nxt;

   assign last_com = (com_idx == CW'(NCOM - 1));

   if ((NCOM & (NCOM - 1)) == 0) begin : g_pow2
      assign com_nxt = com_idx + 1'b1;
   end else begin : g_cmp
      assign com_nxt = last_com ? '0 : com_idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         com_idx     <= '0;
         pol         <= 1'b0;
         frame_pulse <= 1'b0;
      end else begin
         frame_pulse <= ph_adv && last_com;
         if (ph_adv) begin
            com_idx <= com_nxt;
            if (!frame_inv || last_com) begin
               pol <= ~pol;
            end
         end
      end
   end

endmodule

// File: rtl/lcdseq_segsel.sv
module lcdseq_segsel #(
   parameter  int NSEG = 50,
   parameter  int NCOM = 4,
   localparam int CW   = (NCOM > 1) ? $clog2(NCOM) : 1
) (
   input  logic [NSEG*NCOM-1:0] ram_bits,
   input  logic [CW-1:0]        com_idx,
   input  logic                 blank,
   input  logic                 all_on,
   input  logic                 all_off,
   input  logic                 blink_dark,
   output logic [NSEG-1:0]      seg_on
);
   logic [NSEG-1:0] raw;

   for (genvar k = 0; k < NSEG; k++) begin : g_seg
      logic [NCOM-1:0] nib;
      assign nib    = ram_bits[k*NCOM +: NCOM];
      assign raw[k] = nib[com_idx];
   end

   // priority: blank, forced dark, forced lit, blink dark half, memory
   always_comb begin
      if (blank || all_off) begin
         seg_on = '0;
      end else if (all_on) begin
         seg_on = '1;
      end else if (blink_dark) begin
         seg_on = '0;
      end else begin
         seg_on = raw;
      end
   end

endmodule

// File: rtl/lcdseq_levels.sv
module lcdseq_levels #(
   parameter  int NSEG = 50,
   parameter  int NCOM = 4,
   localparam int CW   = (NCOM > 1) ? $clog2(NCOM) : 1
) (
   input  logic [NSEG-1:0]   seg_on,
   input  logic [CW-1:0]     com_idx,
   input  logic              pol,
   input  logic              blank,
   input  logic              half_bias,
   output logic [2*NCOM-1:0] com_lvl,
   output logic [2*NSEG-1:0] seg_lvl
);
   import lcdseq_pkg::*;

   for (genvar n = 0; n < NCOM; n++) begin : g_com
      assign com_lvl[2*n +: 2] = blank ? LV_GND
                                       : com_level(com_idx == CW'(n), pol, half_bias);
   end

   for (genvar k = 0; k < NSEG; k++) begin : g_seg
      assign seg_lvl[2*k +: 2] = blank ? LV_GND
                                       : seg_level(seg_on[k], pol, half_bias);
   end

endmodule

// File: rtl/lcdseq_top.sv
module lcdseq_top #(
   parameter  int NSEG       = 50,
   parameter  int NCOM       = 4,
   parameter  int DIV_R0     = 8,
   parameter  int DIV_R1     = 9,
   parameter  int DIV_R2     = 10,
   parameter  int DIV_R3     = 12,
   parameter  int BLINK_HALF = 640,
   localparam int CW         = (NCOM > 1) ? $clog2(NCOM) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 disp_on,
   input  logic                 inh_n,
   input  logic                 frame_inv,
   input  logic                 half_bias,
   input  logic [1:0]           rate_sel,
   input  logic [1:0]           blink_sel,
   input  logic                 all_on,
   input  logic                 all_off,
   input  logic [NSEG*NCOM-1:0] ram_bits,
   output logic [CW-1:0]        com_sel,
   output logic                 inv_phase,
   output logic                 frame_pulse,
   output logic [NSEG-1:0]      seg_on,
   output logic [2*NCOM-1:0]    com_lvl,
   output logic [2*NSEG-1:0]    seg_lvl
);
   if (NSEG < 1) begin : g_bad_nseg
      $error("lcdseq_top: NSEG must be at least 1");
   end
   if (NCOM < 2) begin : g_bad_ncom
      $error("lcdseq_top: NCOM must be at least 2");
   end

   logic       ph_adv;
   logic [2:0] blink_step;
   logic       blink_dark;
   logic       blank;

   assign blank = !disp_on || !inh_n;

   // the step counter's low bit toggles each half-step: bit 0 → 2 Hz, bit 2 → 0.5 Hz
   always_comb begin
      case (blink_sel)
         2'b01:   blink_dark = blink_step[2];
         2'b10:   blink_dark = blink_step[1];
         2'b11:   blink_dark = blink_step[0];
         default: blink_dark = 1'b0;
      endcase
   end

   lcdseq_timebase #(
      .DIV_R0     (DIV_R0),
      .DIV_R1     (DIV_R1),
      .DIV_R2     (DIV_R2),
      .DIV_R3     (DIV_R3),
      .BLINK_HALF (BLINK_HALF)
   ) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .rate       (rate_sel),
      .ph_adv     (ph_adv),
      .blink_step (blink_step)
   );

   lcdseq_scan #(.NCOM(NCOM)) u_scan (
      .clk         (clk),
      .rst_n       (rst_n),
      .ph_adv      (ph_adv),
      .frame_inv   (frame_inv),
      .com_idx     (com_sel),
      .pol         (inv_phase),
      .frame_pulse (frame_pulse)
   );

   lcdseq_segsel #(.NSEG(NSEG), .NCOM(NCOM)) u_sel (
      .ram_bits   (ram_bits),
      .com_idx    (com_sel),
      .blank      (blank),
      .all_on     (all_on),
      .all_off    (all_off),
      .blink_dark (blink_dark),
      .seg_on     (seg_on)
   );

   lcdseq_levels #(.NSEG(NSEG), .NCOM(NCOM)) u_lvl (
      .seg_on    (seg_on),
      .com_idx   (com_sel),
      .pol       (inv_phase),
      .blank     (blank),
      .half_bias (half_bias),
      .com_lvl   (com_lvl),
      .seg_lvl   (seg_lvl)
   );

endmodule

// File: rtl/lcdseq_chk.sv
module lcdseq_chk #(
   parameter  int NSEG = 50,
   parameter  int NCOM = 4,
   localparam int CW   = (NCOM > 1) ? $clog2(NCOM) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick,
   input logic                 disp_on,
   input logic                 inh_n,
   input logic                 frame_inv,
   input logic                 all_on,
   input logic                 all_off,
   input logic [CW-1:0]        com_sel,
   input logic                 inv_phase,
   input logic                 frame_pulse,
   input logic [NSEG-1:0]      seg_on,
   input logic [2*NCOM-1:0]    com_lvl,
   input logic [2*NSEG-1:0]    seg_lvl
);
   logic [NCOM-1:0] at_full;
   for (genvar n = 0; n < NCOM; n++) begin : g_full
      assign at_full[n] = (com_lvl[2*n +: 2] == (inv_phase ? 2'b00 : 2'b11));
   end

   AST_COM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (com_sel != $past(com_sel)) |->
         (com_sel == (($past(com_sel) == CW'(NCOM - 1)) ? '0 : $past(com_sel) + 1'b1))); // R1

   AST_FRAME_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |-> (com_sel == '0 && $past(com_sel) == CW'(NCOM - 1))); // R3

   AST_FRAME_POL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(frame_inv) && !$stable(inv_phase)) |-> frame_pulse); // R4

   AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!disp_on || !inh_n) |-> (seg_on == '0 && com_lvl == '0 && seg_lvl == '0)); // R5

   AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on && inh_n && all_off) |-> (seg_on == '0)); // R6

   AST_ON_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on && inh_n && all_on && !all_off) |-> (&seg_on)); // R6

   AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on && inh_n) |-> ($countones(at_full) == 1)); // R8

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(com_sel) && $stable(inv_phase))); // R11

endmodule

bind lcdseq_top lcdseq_chk #(.NSEG(NSEG), .NCOM(NCOM)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .disp_on     (disp_on),
   .inh_n       (inh_n),
   .frame_inv   (frame_inv),
   .all_on      (all_on),
   .all_off     (all_off),
   .com_sel     (com_sel),
   .inv_phase   (inv_phase),
   .frame_pulse (frame_pulse),
   .seg_on      (seg_on),
   .com_lvl     (com_lvl),
   .seg_lvl     (seg_lvl)
);

// File: tb/tb_lcdseq_top.sv
`timescale 1ns/1ps
module tb_lcdseq_top;
   localparam int NS = 50;
   localparam int NC = 4;
   localparam int BH = 640;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          disp_on = 1'b0, inh_n = 1'b1, frame_inv = 1'b1, half_bias = 1'b0;
   logic [1:0]    rate_sel = 2'd0, blink_sel = 2'd0;
   logic          all_on = 1'b0, all_off = 1'b0;
   logic [NS*NC-1:0] ram_bits = '0;
   logic [1:0]    com_sel;
   logic          inv_phase, frame_pulse;
   logic [NS-1:0] seg_on;
   logic [2*NC-1:0] com_lvl;
   logic [2*NS-1:0] seg_lvl;

   int checks = 0, errors = 0;
   int tick_mode = 2;
   int tcnt = 0;
   bit cmp_en = 0;

   // reference model state
   int m_ph = 0, m_com = 0, m_pol = 0, m_fp = 0, m_bk = 0, m_bsteps = 0;

   lcdseq_top dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .disp_on(disp_on), .inh_n(inh_n),
      .frame_inv(frame_inv), .half_bias(half_bias), .rate_sel(rate_sel),
      .blink_sel(blink_sel), .all_on(all_on), .all_off(all_off), .ram_bits(ram_bits),
      .com_sel(com_sel), .inv_phase(inv_phase), .frame_pulse(frame_pulse),
      .seg_on(seg_on), .com_lvl(com_lvl), .seg_lvl(seg_lvl));

   always #4 clk = ~clk;

   always @(posedge clk) begin
      #1;
      tcnt++;
      case (tick_mode)
         0:       tick = 1'b1;
         1:       tick = (tcnt % 3 == 0);
         default: tick = 1'b0;
      endcase
   end

   function automatic int ticks_per_phase(input logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 9;
         2'd2:    return 10;
         default: return 12;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_com = 0; m_pol = 0; m_fp = 0; m_bk = 0; m_bsteps = 0;
      end else begin
         m_fp = 0;
         if (tick) begin
            if (m_ph + 1 >= ticks_per_phase(rate_sel)) begin
               m_ph = 0;
               if (m_com == NC - 1) m_fp = 1;
               if (!frame_inv || m_com == NC - 1) m_pol = 1 - m_pol;
               m_com = (m_com + 1) % NC;
            end else begin
               m_ph = m_ph + 1;
            end
            m_bk = m_bk + 1;
            if (m_bk == BH) begin
               m_bk = 0;
               m_bsteps = m_bsteps + 1;
            end
         end
      end
   end

   function automatic bit m_dark();
      case (blink_sel)
         2'd1:    return ((m_bsteps / 4) % 2) == 1;
         2'd2:    return ((m_bsteps / 2) % 2) == 1;
         2'd3:    return (m_bsteps % 2) == 1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [NS-1:0] m_seg();
      logic [NS-1:0] v;
      bit blank;
      blank = !disp_on || !inh_n;
      for (int k = 0; k < NS; k++) begin
         if (blank || all_off)  v[k] = 1'b0;
         else if (all_on)       v[k] = 1'b1;
         else if (m_dark())     v[k] = 1'b0;
         else                   v[k] = ram_bits[NC*k + m_com];
      end
      return v;
   endfunction

   function automatic logic [2*NC-1:0] m_comlvl();
      logic [2*NC-1:0] v;
      for (int n = 0; n < NC; n++) begin
         int c;
         if (!disp_on || !inh_n) c = 0;
         else if (n == m_com)    c = (m_pol == 1) ? 0 : 3;
         else if (half_bias)     c = 1;
         else                    c = (m_pol == 1) ? 2 : 1;
         v[2*n +: 2] = 2'(c);
      end
      return v;
   endfunction

   function automatic logic [2*NS-1:0] m_seglvl(input logic [NS-1:0] lit);
      logic [2*NS-1:0] v;
      for (int k = 0; k < NS; k++) begin
         int c;
         if (!disp_on || !inh_n) c = 0;
         else if (lit[k])        c = (m_pol == 1) ? 3 : 0;
         else if (half_bias)     c = 1;
         else                    c = (m_pol == 1) ? 1 : 2;
         v[2*k +: 2] = 2'(c);
      end
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         logic [NS-1:0] es;
         es = m_seg();
         chk(com_sel == 2'(m_com), "R1 com_sel", 128'(com_sel), 128'(m_com));
         chk(frame_pulse == 1'(m_fp), "R3 frame_pulse", 128'(frame_pulse), 128'(m_fp));
         chk(inv_phase == 1'(m_pol), "R4 inv_phase", 128'(inv_phase), 128'(m_pol));
         chk(seg_on == es, "R2 R5 R6 R7 seg_on", 128'(seg_on), 128'(es));
         chk(com_lvl == m_comlvl(), "R8 R9 R5 com_lvl", 128'(com_lvl), 128'(m_comlvl()));
         chk(seg_lvl == m_seglvl(es), "R8 R9 R5 seg_lvl", 128'(seg_lvl), 128'(m_seglvl(es)));
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic measure_phase(input logic [1:0] code);
      int c;
      logic [1:0] prev;
      rate_sel = code;
      @(negedge clk);
      prev = com_sel;
      while (com_sel == prev) @(negedge clk);
      prev = com_sel;
      c = 0;
      while (com_sel == prev && c < 100) begin
         @(negedge clk);
         c++;
      end
      chk(c == ticks_per_phase(code), "R1 phase length", 128'(c), 128'(ticks_per_phase(code)));
      step(1);
   endtask

   task automatic count_frames(input logic [1:0] code, input int exp);
      int n, g;
      bit prev;
      blink_sel = code;
      @(negedge clk);
      prev = seg_on[0];
      g = 0;
      while (!(prev == 1'b0 && seg_on[0] == 1'b1) && g < 20000) begin
         prev = seg_on[0];
         @(negedge clk);
         g++;
      end
      n = 0;
      prev = seg_on[0];
      @(negedge clk);
      while (!(prev == 1'b0 && seg_on[0] == 1'b1) && g < 40000) begin
         if (frame_pulse) n++;
         prev = seg_on[0];
         @(negedge clk);
         g++;
      end
      if (frame_pulse) n++;
      chk(n == exp, "R7 frames per blink period", 128'(n), 128'(exp));
      step(1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired R1 act=running exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [1:0] held_com;
      logic held_pol;
      step(5);
      @(negedge clk);
      // R10 reset state
      chk(com_sel == 2'd0, "R10 reset com_sel", 128'(com_sel), 128'(0));
      chk(inv_phase == 1'b0, "R10 reset inv_phase", 128'(inv_phase), 128'(0));
      chk(frame_pulse == 1'b0, "R10 reset frame_pulse", 128'(frame_pulse), 128'(0));
      step(1);
      rst_n = 1'b1;
      cmp_en = 1;
      disp_on = 1'b1;
      for (int i = 0; i < NS*NC; i++) ram_bits[i] = ((i * 7 + 3) % 5) < 2;
      tick_mode = 0;
      step(300);                                  // R2 frame inversion, 1/3 bias
      measure_phase(2'd0);
      measure_phase(2'd1);
      measure_phase(2'd2);
      measure_phase(2'd3);
      rate_sel = 2'd0;
      frame_inv = 1'b0;
      step(200);                                  // R4 line inversion
      half_bias = 1'b1;
      for (int i = 0; i < NS*NC; i++) ram_bits[i] = (i % 3) == 0;
      step(200);                                  // R9
      half_bias = 1'b0;
      all_on = 1'b1;
      step(100);
      all_off = 1'b1;
      step(100);                                  // R6 off beats on
      all_on = 1'b0;
      step(100);
      all_off = 1'b0;
      all_on = 1'b1;
      blink_sel = 2'd3;
      step(1500);                                 // R6 on beats blink
      @(negedge clk);
      chk(&seg_on, "R6 all_on during blink", 128'(seg_on), {78'd0, {50{1'b1}}});
      step(1);
      all_on = 1'b0;
      blink_sel = 2'd0;
      disp_on = 1'b0;
      step(100);                                  // R5 display off
      disp_on = 1'b1;
      inh_n = 1'b0;
      step(100);                                  // R5 inhibit
      @(negedge clk);
      chk(seg_lvl == '0, "R5 inhibit levels", 128'(seg_lvl), 128'(0));
      step(1);
      inh_n = 1'b1;
      tick_mode = 1;
      step(300);
      tick_mode = 2;
      step(2);
      @(negedge clk);
      held_com = com_sel;
      held_pol = inv_phase;
      repeat (40) @(negedge clk);
      chk(com_sel == held_com, "R11 com_sel held", 128'(com_sel), 128'(held_com));
      chk(inv_phase == held_pol, "R11 inv_phase held", 128'(inv_phase), 128'(held_pol));
      step(1);
      tick_mode = 0;
      frame_inv = 1'b1;
      ram_bits = '1;
      step(2);
      count_frames(2'd3, 40);
      count_frames(2'd2, 80);
      count_frames(2'd1, 160);
      step(5);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule